// File: doc/BRIEF.md
# Status Channel DIP-2 Validator

This block sits on the transmit side of a SPI-4.2 link and decodes the 2-bit status channel coming back from the far end. Status arrives as frames. Each frame opens with the framing code `11`. It then carries one status word per calendar slot, for `length × multiplier` slots, and closes with a DIP-2 check word. Slot `k` of a frame reports on port `k mod length`. The block keeps one 2-bit status per port and presents all of them to a downstream scheduler. An update strobe marks each change, and a DIP-2 error flag marks each failed check. The status codes are `00` for starving, `01` for hungry and `10` for satisfied. `11` is never a status value.

A per-frame commit policy is chosen by `pess_mode_i`. In pessimistic mode the frame's statuses are collected in a shadow buffer. They reach the outputs, all in one cycle, only when the check word matches. A frame that fails the check is dropped, and the next frame overwrites the shadow. Valid status therefore appears about `length × multiplier` status cycles later than in optimistic mode. In optimistic mode every status word is forwarded as soon as it is sampled. A failed check only raises the error flag.

A three-state machine tracks the frame:
- `ST_HUNT` waits for the framing code. Seeing it moves the machine to `ST_WORDS`.
- `ST_WORDS` counts status slots. A stray framing code here restarts the frame and the machine stays in `ST_WORDS`. The last slot moves it to `ST_PARITY`.
- `ST_PARITY` consumes the check word and always returns to `ST_HUNT`.

Top module: `sdv_status_validator`

## Requirements
- R1: After reset every port status is `00`, and the update strobe and the error flag are low.
- R2: While hunting for a frame, any word other than `11` is ignored: no strobe, no error, no status change. `11` starts a frame.
- R3: Calendar order and frame length:
  - Data word `k` of a frame belongs to port `k mod L`.
  - A frame holds `L × M` data words followed by one check word. The check word may take any value, including `11`.
  - `L`, `M` and the mode are captured from the inputs in the framing cycle. `L` is clamped to 1..NPORTS and `M` to at least 1.
- R4: The check word matches when it equals the bitwise inverse of the XOR of all data words since the last framing code. This makes every bit column, including the check bit, have odd parity.
- R5: In pessimistic mode no status changes during a frame. In the cycle after the matching check word is sampled, all buffered ports change together and the update strobe is high for exactly that one cycle.
- R6: In pessimistic mode a mismatching check word leaves every status unchanged and gives no strobe. The next frame's words replace the discarded buffer.
- R7: In optimistic mode, in the cycle after a data word is sampled, that word appears on its port and the update strobe is high.
- R8: A mismatching check word raises `dip_err_o` for exactly the one cycle after it is sampled. In optimistic mode the already-forwarded statuses stay as they are.
- R9: A `11` received among a frame's data words discards the partial frame. The slot count and the parity restart from zero, and no data from the discarded part is ever committed.
- R10: Ports with index at or above the captured length keep their values through commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Status clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stat_i | input | 2 | Status channel word sampled every cycle |
| cal_len_i | input | $clog2(NPORTS+1) | Calendar length L, captured at the framing code |
| cal_mult_i | input | MULT_W | Calendar multiplier M, captured at the framing code |
| pess_mode_i | input | 1 | 1 = pessimistic commit, 0 = optimistic pass-through |
| port_status_o | output | 2*NPORTS | Port p status on bits [2p+1:2p] |
| upd_o | output | 1 | One-cycle strobe marking a status change |
| dip_err_o | output | 1 | One-cycle pulse after a mismatching check word |

## Verification
The directed tests target the following cases, each with the failure it would expose:
- **Mid-frame restart.** A partial frame whose words change the running parity is followed by a restart. A design that keeps the old parity would flag the restarted frame as bad. A design that commits the partial words would show them on the ports.
- **Multiplier of two.** A design that ignores the multiplier would end the frame early and take a data word as the check.
- **Check word equal to `11`.** This separates the parity state from framing. A design that confuses the two would hang waiting for data instead of committing.
- **Failed check.** The ports must show no change. A design that commits anyway, or holds the error flag, is caught in the cycles right after the check.
- **Ports above the length.** A short calendar must leave the higher ports untouched.
- **Length, multiplier and mode changed mid-frame.** A design that does not capture them at the framing code would expect more words, or forward words, where it should commit.

// File: rtl/sdv_pkg.sv
package sdv_pkg;
    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_WORDS  = 2'd1,
        ST_PARITY = 2'd2
    } sdv_state_e;

    localparam logic [1:0] FRAME_CODE = 2'b11;
endpackage

// File: rtl/sdv_sequencer.sv
module sdv_sequencer
    import sdv_pkg::*;
#(
    parameter int NPORTS = 8,
    parameter int MULT_W = 3,
    localparam int LEN_W  = $clog2(NPORTS + 1),
    localparam int PORT_W = $clog2(NPORTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        stat_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [MULT_W-1:0] mult_i,
    input  logic              mode_i,
    output logic              frame_start_o,
    output logic              word_we_o,
    output logic              parity_cyc_o,
    output logic [PORT_W-1:0] word_port_o,
    output logic [LEN_W-1:0]  len_o,
    output logic              mode_o
);
    sdv_state_e st_q, st_d;
    logic [LEN_W-1:0]  len_q, len_clamp;
    logic [MULT_W-1:0] mult_q, mult_clamp;
    logic [PORT_W-1:0] port_q;
    logic [MULT_W-1:0] round_q;
    logic              mode_q;
    logic              at_row_end, last_word;

    // configuration clamp, applied when captured
    always_comb begin
        len_clamp = len_i;
        if (len_i == '0)
            len_clamp = LEN_W'(1);
        else if (len_i > LEN_W'(NPORTS))
            len_clamp = LEN_W'(NPORTS);
        mult_clamp = (mult_i == '0) ? MULT_W'(1) : mult_i;
    end

    // output decode per state
    always_comb begin
        frame_start_o = 1'b0;
        word_we_o     = 1'b0;
        parity_cyc_o  = 1'b0;
        unique case (st_q)
            ST_HUNT:   frame_start_o = (stat_i == FRAME_CODE);
            ST_WORDS: begin
                frame_start_o = (stat_i == FRAME_CODE);
                word_we_o     = (stat_i != FRAME_CODE);
            end
            ST_PARITY: parity_cyc_o = 1'b1;
            default: ;
        endcase
    end

    assign at_row_end = (LEN_W'(port_q) == len_q - LEN_W'(1));
    assign last_word  = word_we_o && at_row_end && (round_q == mult_q - MULT_W'(1));

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HUNT:   if (frame_start_o) st_d = ST_WORDS;
            ST_WORDS:  if (last_word)     st_d = ST_PARITY;
            ST_PARITY: st_d = ST_HUNT;
            default:   st_d = ST_HUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_HUNT;
        else        st_q <= st_d;
    end

    // slot counters and captured configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q  <= '0;
            round_q <= '0;
            len_q   <= LEN_W'(1);
            mult_q  <= MULT_W'(1);
            mode_q  <= 1'b1;
        end else if (frame_start_o) begin
            port_q  <= '0;
            round_q <= '0;
            len_q   <= len_clamp;
            mult_q  <= mult_clamp;
            mode_q  <= mode_i;
        end else if (word_we_o) begin
            if (at_row_end) begin
                port_q  <= '0;
                round_q <= round_q + MULT_W'(1);
            end else begin
                port_q  <= port_q + PORT_W'(1);
            end
        end
    end

    assign word_port_o = port_q;
    assign len_o       = len_q;
    assign mode_o      = mode_q;

    // R3: slot index stays inside the captured calendar
    a_r3_port_in_calendar: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WORDS) |-> (LEN_W'(port_q) < len_q));

    // R9: stray framing code among data restarts the count
    a_r9_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WORDS && stat_i == FRAME_CODE)
        |=> (st_q == ST_WORDS && port_q == '0 && round_q == '0));

    // R2: idle words keep the machine hunting
    a_r2_idle_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HUNT && stat_i != FRAME_CODE) |=> (st_q == ST_HUNT));
endmodule

// File: rtl/sdv_dip2.sv
module sdv_dip2 (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start_i,
    input  logic       word_we_i,
    input  logic       parity_cyc_i,
    input  logic [1:0] stat_i,
    output logic       pass_o,
    output logic       fail_o
);
    logic [1:0] acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n)             acc_q <= '0;
        else if (frame_start_i) acc_q <= '0;
        else if (word_we_i)     acc_q <= acc_q ^ stat_i;
    end

    assign pass_o = parity_cyc_i && (stat_i == ~acc_q);
    assign fail_o = parity_cyc_i && (stat_i != ~acc_q);

    // R3: the check word always follows a data word
    a_r3_parity_after_word: assert property (@(posedge clk) disable iff (!rst_n)
        parity_cyc_i |-> $past(word_we_i));
endmodule

// File: rtl/sdv_commit.sv
module sdv_commit #(
    parameter int NPORTS = 8,
    parameter int LEN_W  = 4,
    parameter int PORT_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pess_i,
    input  logic                word_we_i,
    input  logic [PORT_W-1:0]   port_i,
    input  logic [1:0]          stat_i,
    input  logic [LEN_W-1:0]    len_i,
    input  logic                pass_i,
    input  logic                fail_i,
    output logic [2*NPORTS-1:0] status_o,
    output logic                upd_o,
    output logic                err_o
);
    logic [1:0] shadow_q [NPORTS];
    logic [1:0] live_q   [NPORTS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NPORTS; p++) begin
                shadow_q[p] <= '0;
                live_q[p]   <= '0;
            end
            upd_o <= 1'b0;
            err_o <= 1'b0;
        end else begin
            upd_o <= (word_we_i && !pess_i) || (pess_i && pass_i);
            err_o <= fail_i;
            if (word_we_i) begin
                shadow_q[port_i] <= stat_i;
                if (!pess_i) live_q[port_i] <= stat_i;
            end
            if (pess_i && pass_i) begin
                for (int p = 0; p < NPORTS; p++)
                    if (LEN_W'(p) < len_i) live_q[p] <= shadow_q[p];
            end
        end
    end

    for (genvar g = 0; g < NPORTS; g++) begin : g_flat
        assign status_o[2*g +: 2] = live_q[g];
    end

    // R5: outputs never move without the strobe
    a_r5_change_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_o |-> $stable(status_o));

    // R5: a pessimistic commit is always preceded by a passing check
    a_r5_commit_after_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_o && $past(pess_i)) |-> $past(pass_i));

    // R8: error flag is a single-cycle pulse
    a_r8_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

    // R6: a failed check never comes with an update
    a_r6_no_strobe_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !upd_o);
endmodule

// File: rtl/sdv_status_validator.sv
module sdv_status_validator #(
    parameter int NPORTS = 8,
    parameter int MULT_W = 3,
    localparam int LEN_W  = $clog2(NPORTS + 1),
    localparam int PORT_W = $clog2(NPORTS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          stat_i,
    input  logic [LEN_W-1:0]    cal_len_i,
    input  logic [MULT_W-1:0]   cal_mult_i,
    input  logic                pess_mode_i,
    output logic [2*NPORTS-1:0] port_status_o,
    output logic                upd_o,
    output logic                dip_err_o
);
    logic              frame_start, word_we, parity_cyc, pass, fail, mode_q;
    logic [PORT_W-1:0] word_port;
    logic [LEN_W-1:0]  len_q;

    sdv_sequencer #(.NPORTS(NPORTS), .MULT_W(MULT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .stat_i(stat_i),
        .len_i(cal_len_i), .mult_i(cal_mult_i), .mode_i(pess_mode_i),
        .frame_start_o(frame_start), .word_we_o(word_we), .parity_cyc_o(parity_cyc),
        .word_port_o(word_port), .len_o(len_q), .mode_o(mode_q)
    );

    sdv_dip2 u_dip (
        .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start),
        .word_we_i(word_we), .parity_cyc_i(parity_cyc), .stat_i(stat_i),
        .pass_o(pass), .fail_o(fail)
    );

    sdv_commit #(.NPORTS(NPORTS), .LEN_W(LEN_W), .PORT_W(PORT_W)) u_commit (
        .clk(clk), .rst_n(rst_n), .pess_i(mode_q), .word_we_i(word_we),
        .port_i(word_port), .stat_i(stat_i), .len_i(len_q),
        .pass_i(pass), .fail_i(fail),
        .status_o(port_status_o), .upd_o(upd_o), .err_o(dip_err_o)
    );
endmodule

// File: tb/sim_sdv_status_validator.sv
`timescale 1ns/1ps
module sim_sdv_status_validator;
    localparam int NP = 8;
    localparam int MW = 3;
    localparam int LW = $clog2(NP + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      stat;
    logic [LW-1:0]   len;
    logic [MW-1:0]   mult;
    logic            pess;
    logic [2*NP-1:0] st_o;
    logic            upd, err;

    int n_cmp = 0;
    int n_bad = 0;
    logic [1:0] expv [NP];
    logic [1:0] wb [32];

    always #5 clk = ~clk;

    sdv_status_validator #(.NPORTS(NP), .MULT_W(MW)) u0 (
        .clk(clk), .rst_n(rst_n), .stat_i(stat), .cal_len_i(len),
        .cal_mult_i(mult), .pess_mode_i(pess),
        .port_status_o(st_o), .upd_o(upd), .dip_err_o(err)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [2*NP-1:0] exp_vec();
        logic [2*NP-1:0] v;
        for (int p = 0; p < NP; p++) v[2*p +: 2] = expv[p];
        return v;
    endfunction

    function automatic logic [1:0] dip_of(int n);
        logic [1:0] a = '0;
        for (int i = 0; i < n; i++) a ^= wb[i];
        return ~a;
    endfunction

    task automatic send(input logic [1:0] w);
        stat = w;
        @(negedge clk);
    endtask

    task automatic check_outs(string req, logic eu, logic ee);
        check(req, "status", st_o, exp_vec());
        check(req, "update", upd, eu);
        check(req, "dip_err", err, ee);
    endtask

    task automatic t_reset();
        check_outs("R1 reset", 1'b0, 1'b0);
    endtask

    task automatic t_pess_pass();
        pess = 1'b1; len = 4; mult = 1;
        wb[0] = 2'b01; wb[1] = 2'b10; wb[2] = 2'b00; wb[3] = 2'b01;
        send(2'b11);
        check_outs("R5 framing", 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) begin
            send(wb[i]);
            check_outs("R5 no early commit", 1'b0, 1'b0);
        end
        send(dip_of(4));
        for (int p = 0; p < 4; p++) expv[p] = wb[p];
        check_outs("R4 R5 commit", 1'b1, 1'b0);
        send(2'b00);
        check_outs("R5 strobe width", 1'b0, 1'b0);
    endtask

    task automatic t_idle();
        send(2'b01); check_outs("R2 idle", 1'b0, 1'b0);
        send(2'b10); check_outs("R2 idle", 1'b0, 1'b0);
        send(2'b00); check_outs("R2 idle", 1'b0, 1'b0);
    endtask

    task automatic t_pess_fail();
        pess = 1'b1; len = 4; mult = 1;
        for (int i = 0; i < 4; i++) wb[i] = 2'b10;
        send(2'b11);
        for (int i = 0; i < 4; i++) send(wb[i]);
        send(dip_of(4) ^ 2'b01);
        check_outs("R6 failed check", 1'b0, 1'b1);
        send(2'b00);
        check_outs("R6 R8 err one cycle", 1'b0, 1'b0);
        wb[0] = 2'b00; wb[1] = 2'b01; wb[2] = 2'b10; wb[3] = 2'b01;
        send(2'b11);
        for (int i = 0; i < 4; i++) send(wb[i]);
        send(dip_of(4));
        for (int p = 0; p < 4; p++) expv[p] = wb[p];
        check_outs("R6 overwrite", 1'b1, 1'b0);
    endtask

    task automatic t_pess_mult();
        pess = 1'b1; len = 3; mult = 2;
        wb[0] = 2'b01; wb[1] = 2'b01; wb[2] = 2'b01;
        wb[3] = 2'b10; wb[4] = 2'b00; wb[5] = 2'b01;
        send(2'b11);
        for (int i = 0; i < 6; i++) begin
            send(wb[i]);
            check("R3 multiplier", "update", upd, 1'b0);
        end
        send(dip_of(6));
        expv[0] = 2'b10; expv[1] = 2'b00; expv[2] = 2'b01;
        check_outs("R3 two rounds", 1'b1, 1'b0);
        check("R10 ports beyond length", "port3", st_o[7:6], 2'b01);
    endtask

    task automatic t_restart();
        pess = 1'b1; len = 4; mult = 1;
        send(2'b11);
        send(2'b10);
        send(2'b01);
        send(2'b11);
        check_outs("R9 restart", 1'b0, 1'b0);
        wb[0] = 2'b01; wb[1] = 2'b00; wb[2] = 2'b01; wb[3] = 2'b10;
        for (int i = 0; i < 4; i++) send(wb[i]);
        send(dip_of(4));
        for (int p = 0; p < 4; p++) expv[p] = wb[p];
        check_outs("R9 restarted frame", 1'b1, 1'b0);
    endtask

    task automatic t_opt();
        pess = 1'b0; len = 4; mult = 1;
        wb[0] = 2'b10; wb[1] = 2'b01; wb[2] = 2'b10; wb[3] = 2'b00;
        send(2'b11);
        check_outs("R7 framing", 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) begin
            send(wb[i]);
            expv[i] = wb[i];
            check_outs("R7 forward", 1'b1, 1'b0);
        end
        send(dip_of(4) ^ 2'b10);
        check_outs("R8 error kept values", 1'b0, 1'b1);
        send(2'b00);
        check_outs("R8 err one cycle", 1'b0, 1'b0);
    endtask

    task automatic t_latch();
        pess = 1'b1; len = 2; mult = 1;
        wb[0] = 2'b10; wb[1] = 2'b10;
        send(2'b11);
        len = 5; mult = 3; pess = 1'b0;
        send(wb[0]);
        check_outs("R3 captured mode", 1'b0, 1'b0);
        send(wb[1]);
        check_outs("R3 captured mode", 1'b0, 1'b0);
        send(dip_of(2));
        expv[0] = 2'b10; expv[1] = 2'b10;
        check_outs("R3 captured length, check 11", 1'b1, 1'b0);
        check("R10 ports beyond length", "port2", st_o[5:4], 2'b10);
        len = 4; mult = 1; pess = 1'b1;
    endtask

    initial begin
        stat = 2'b00; len = 4; mult = 1; pess = 1'b1;
        for (int p = 0; p < NP; p++) expv[p] = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pess_pass();
        t_idle();
        t_pess_fail();
        t_pess_mult();
        t_restart();
        t_opt();
        t_latch();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule